// File: doc/BRIEF.md
# Load-Dependent Switching Mode Controller

This block chooses between fixed-frequency PWM operation and hysteretic operation for a buck converter, based on what the switching node reveals about inductor current. Once per switching period a one-clock cycle strobe marks the moment to sample the phase-node comparator. A high sample means the inductor current stayed continuous. A low sample means it went discontinuous, which is the sign of a light load.

The mode changes only after an unbroken run of same-level samples. The run is eight by default and is set by a parameter. One contrary sample resets the run to zero, so the mode cannot toggle back and forth near the critical load. The mode register drives a pair of complementary flags. The block also gates the PWM-path and hysteretic-path enable inputs according to the mode. In hysteretic mode it blocks the low-side gate after a zero-current crossing, so the synchronous rectifier acts like a diode and never conducts in reverse.

Top module: `load_mode_ctl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `normal_o`=1, `hyst_o`=0, `pwm_path_o`=0, `hyst_path_o`=0, `ls_gate_o`=0 and `hs_gate_o`=0, and both run counts are zero.
- R2: `normal_o` is always the inverse of `hyst_o`. `hyst_o`=1 means hysteretic mode.
- R3: In PWM mode, RUN_LEN consecutive strobed samples with `phase_cmp_i`=0 set `hyst_o` at the clock edge that takes the last of them. RUN_LEN-1 such samples leave the mode unchanged.
- R4: In PWM mode, a strobed sample with `phase_cmp_i`=1 never enters hysteretic mode and restarts the low-sample run at zero.
- R5: In hysteretic mode, RUN_LEN consecutive strobed samples with `phase_cmp_i`=1 clear `hyst_o` at the clock edge that takes the last of them.
- R6: In hysteretic mode, a strobed sample with `phase_cmp_i`=0 keeps the mode and restarts the high-sample run at zero.
- R7: On cycles with `cyc_stb_i`=0 the mode does not change, `phase_cmp_i` is ignored, and both run counts hold their values.
- R8: A mode change clears both run counts, so a return to the previous mode needs a full RUN_LEN run counted from the first strobe after the change.
- R9: `pwm_path_o` is `pwm_cmp_i` registered one cycle and forced to 0 when the mode is hysteretic in the input cycle. `hyst_path_o` is `hyst_cmp_i` registered one cycle and forced to 0 when the mode is PWM.
- R10: `hs_gate_o` is `hs_on_i` delayed one cycle. `ls_gate_o` is `ls_req_i` delayed one cycle. The exception: in hysteretic mode, once `zc_det_i`=1 is seen, `ls_gate_o` is held at 0 from the next cycle. The hold ends in the cycle where `hs_on_i`=1. In PWM mode `zc_det_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb_i | input | 1 | One-clock strobe, once per switching cycle |
| phase_cmp_i | input | 1 | Phase-node comparator (1 = continuous current) |
| pwm_cmp_i | input | 1 | PWM comparator / error-amp path request |
| hyst_cmp_i | input | 1 | Hysteretic comparator path request |
| hs_on_i | input | 1 | High-side turn-on request |
| ls_req_i | input | 1 | Low-side gate request |
| zc_det_i | input | 1 | Inductor zero-current crossing detected |
| hyst_o | output | 1 | Hysteretic mode flag |
| normal_o | output | 1 | PWM mode flag |
| pwm_path_o | output | 1 | Gated PWM path enable |
| hyst_path_o | output | 1 | Gated hysteretic path enable |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable with diode-emulation blocking |

## Verification
Every 10-sample strobe sequence is driven from both starting modes, 2048 runs in total. Any high/low mix at a run boundary therefore separates a controller that restarts its run on a contrary sample from one that only pauses or decrements. Each strobe is followed by an idle cycle with the opposite comparator level, which shows whether non-strobe cycles leak into the count. Sequences of exactly seven and exactly eight samples pin down the threshold. Separate directed cases flip the mode and then watch the path gating and the low-side blocking, set and release, in each mode.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_HYST = 1'b1
  } mode_e;
endpackage

// File: rtl/mc_run_counter.sv
// Counts consecutive strobed samples equal to LEVEL while armed.
module mc_run_counter #(
  parameter int RUN_LEN = 8,
  parameter bit LEVEL   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic stb,
  input  logic smp,
  input  logic clr,
  output logic full
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          match;

  assign match = arm && stb && (smp == LEVEL);
  assign full  = match && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !arm) begin
      cnt_q <= '0;
    end else if (stb) begin
      if (smp == LEVEL) cnt_q <= cnt_q + 1'b1;
      else              cnt_q <= '0;
    end
  end
endmodule

// File: rtl/mc_dio_gate.sv
// Gate drive with diode emulation of the synchronous rectifier.
module mc_dio_gate (
  input  logic clk,
  input  logic rst,
  input  logic emu_en,
  input  logic zc_det,
  input  logic hs_on,
  input  logic ls_req,
  output logic hs_gate,
  output logic ls_gate
);
  logic blk_q;
  logic blk_nxt;

  always_comb begin
    if (!emu_en || hs_on) blk_nxt = 1'b0;
    else if (zc_det)      blk_nxt = 1'b1;
    else                  blk_nxt = blk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q   <= 1'b0;
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
    end else begin
      blk_q   <= blk_nxt;
      hs_gate <= hs_on;
      ls_gate <= ls_req && !blk_nxt;
    end
  end
endmodule

// File: rtl/load_mode_ctl.sv
module load_mode_ctl #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_stb_i,
  input  logic phase_cmp_i,
  input  logic pwm_cmp_i,
  input  logic hyst_cmp_i,
  input  logic hs_on_i,
  input  logic ls_req_i,
  input  logic zc_det_i,
  output logic hyst_o,
  output logic normal_o,
  output logic pwm_path_o,
  output logic hyst_path_o,
  output logic hs_gate_o,
  output logic ls_gate_o
);
  import mode_ctl_pkg::*;

  localparam int NDIR = 2;

  mode_e            mode_q;
  mode_e            mode_nxt;
  logic [NDIR-1:0]  full;
  logic             flip;

  // Direction d is armed in mode d and counts samples equal to d:
  // d=0 counts lows in PWM mode, d=1 counts highs in hysteretic mode.
  for (genvar d = 0; d < NDIR; d++) begin : g_run
    mc_run_counter #(
      .RUN_LEN (RUN_LEN),
      .LEVEL   (d[0])
    ) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .arm  (mode_q == mode_e'(d[0])),
      .stb  (cyc_stb_i),
      .smp  (phase_cmp_i),
      .clr  (flip),
      .full (full[d])
    );
  end

  assign flip = |full;

  always_comb begin
    mode_nxt = mode_q;
    if (full[0])      mode_nxt = MODE_HYST;
    else if (full[1]) mode_nxt = MODE_PWM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_PWM;
      normal_o    <= 1'b1;
      pwm_path_o  <= 1'b0;
      hyst_path_o <= 1'b0;
    end else begin
      mode_q      <= mode_nxt;
      normal_o    <= (mode_nxt == MODE_PWM);
      pwm_path_o  <= pwm_cmp_i  && (mode_q == MODE_PWM);
      hyst_path_o <= hyst_cmp_i && (mode_q == MODE_HYST);
    end
  end

  assign hyst_o = (mode_q == MODE_HYST);

  mc_dio_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .emu_en  (mode_q == MODE_HYST),
    .zc_det  (zc_det_i),
    .hs_on   (hs_on_i),
    .ls_req  (ls_req_i),
    .hs_gate (hs_gate_o),
    .ls_gate (ls_gate_o)
  );
endmodule

// File: rtl/load_mode_ctl_chk.sv
module load_mode_ctl_chk (
  input logic clk,
  input logic rst,
  input logic cyc_stb_i,
  input logic phase_cmp_i,
  input logic pwm_cmp_i,
  input logic hyst_cmp_i,
  input logic hs_on_i,
  input logic zc_det_i,
  input logic hyst_o,
  input logic normal_o,
  input logic pwm_path_o,
  input logic hyst_path_o,
  input logic ls_gate_o
);
  AST_FLAGS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    normal_o != hyst_o); // R2

  AST_HIGH_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!hyst_o && cyc_stb_i && phase_cmp_i) |=> !hyst_o); // R4

  AST_LOW_NO_EXIT: assert property (@(posedge clk) disable iff (rst)
    (hyst_o && cyc_stb_i && !phase_cmp_i) |=> hyst_o); // R6

  AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cyc_stb_i |=> $stable(hyst_o)); // R7

  AST_PWM_PATH_GATED: assert property (@(posedge clk) disable iff (rst)
    (hyst_o || !pwm_cmp_i) |=> !pwm_path_o); // R9

  AST_HYST_PATH_GATED: assert property (@(posedge clk) disable iff (rst)
    (!hyst_o || !hyst_cmp_i) |=> !hyst_path_o); // R9

  AST_LS_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (hyst_o && zc_det_i && !hs_on_i) |=> !ls_gate_o); // R10
endmodule

bind load_mode_ctl load_mode_ctl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cyc_stb_i   (cyc_stb_i),
  .phase_cmp_i (phase_cmp_i),
  .pwm_cmp_i   (pwm_cmp_i),
  .hyst_cmp_i  (hyst_cmp_i),
  .hs_on_i     (hs_on_i),
  .zc_det_i    (zc_det_i),
  .hyst_o      (hyst_o),
  .normal_o    (normal_o),
  .pwm_path_o  (pwm_path_o),
  .hyst_path_o (hyst_path_o),
  .ls_gate_o   (ls_gate_o)
);

// File: tb/load_mode_ctl_tb.sv
module load_mode_ctl_tb;
  localparam int RUN_LEN = 8;
  localparam int SEQ_LEN = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_stb_i = 1'b0, phase_cmp_i = 1'b0, pwm_cmp_i = 1'b0, hyst_cmp_i = 1'b0;
  logic hs_on_i = 1'b0, ls_req_i = 1'b0, zc_det_i = 1'b0;
  logic hyst_o, normal_o, pwm_path_o, hyst_path_o, hs_gate_o, ls_gate_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit mdl_hyst;
  int mdl_cnt;

  always #10 clk = ~clk;

  load_mode_ctl #(.RUN_LEN(RUN_LEN)) u_dut (
    .clk, .rst, .cyc_stb_i, .phase_cmp_i, .pwm_cmp_i, .hyst_cmp_i,
    .hs_on_i, .ls_req_i, .zc_det_i, .hyst_o, .normal_o, .pwm_path_o,
    .hyst_path_o, .hs_gate_o, .ls_gate_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 195000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 195000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cyc_stb_i = 0; phase_cmp_i = 0; pwm_cmp_i = 0; hyst_cmp_i = 0;
    hs_on_i = 0; ls_req_i = 0; zc_det_i = 0;
    @(negedge clk);
    rst = 1'b0;
    mdl_hyst = 0;
    mdl_cnt = 0;
  endtask

  // Reference: run length counted per requirement R3..R8.
  function automatic void mdl_step(input bit s);
    bit want = mdl_hyst;  // hysteretic waits for highs, PWM for lows
    if (s == want) begin
      mdl_cnt++;
      if (mdl_cnt == RUN_LEN) begin
        mdl_hyst = !mdl_hyst;
        mdl_cnt = 0;
      end
    end else begin
      mdl_cnt = 0;
    end
  endfunction

  // One strobed sample, then an idle cycle with the opposite level (R7).
  task automatic strobe(input bit s, input bit check);
    @(negedge clk);
    cyc_stb_i = 1'b1; phase_cmp_i = s;
    @(negedge clk);
    mdl_step(s);
    if (check) begin
      chk("R3/R4/R5/R6/R8 mode", hyst_o, mdl_hyst);
      chk("R2 complement", normal_o, !mdl_hyst);
    end
    cyc_stb_i = 1'b0; phase_cmp_i = !s;
  endtask

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 normal", normal_o, 1); chk("R1 hyst", hyst_o, 0);
    chk("R1 pwm_path", pwm_path_o, 0); chk("R1 hyst_path", hyst_path_o, 0);
    chk("R1 ls_gate", ls_gate_o, 0); chk("R1 hs_gate", hs_gate_o, 0);

    // Exhaustive 10-sample sequences from each starting mode (R3..R8, R7 via idle cycles)
    for (int start = 0; start < 2; start++) begin
      for (int p = 0; p < (1 << SEQ_LEN); p++) begin
        do_reset();
        if (start == 1) begin
          for (int k = 0; k < RUN_LEN; k++) strobe(1'b0, 1'b0);
          chk("R3 entry", hyst_o, 1);
        end
        for (int k = 0; k < SEQ_LEN; k++) strobe(p[k], 1'b1);
      end
    end

    // R3 threshold: seven lows keep PWM, eighth switches
    do_reset();
    for (int k = 0; k < RUN_LEN - 1; k++) strobe(1'b0, 1'b0);
    chk("R3 seven lows", hyst_o, 0);
    strobe(1'b0, 1'b0);
    chk("R3 eighth low", hyst_o, 1);
    // R7 long idle with high comparator: no change, count held
    repeat (5) @(negedge clk);
    phase_cmp_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 idle hold", hyst_o, 1);
    // R8 after entry, seven highs insufficient
    for (int k = 0; k < RUN_LEN - 1; k++) strobe(1'b1, 1'b0);
    chk("R8 seven highs", hyst_o, 1);

    // R9 path gating in hysteretic mode
    @(negedge clk); pwm_cmp_i = 1; hyst_cmp_i = 1;
    @(negedge clk);
    chk("R9 pwm_path in hyst", pwm_path_o, 0);
    chk("R9 hyst_path in hyst", hyst_path_o, 1);

    // R10 diode emulation in hysteretic mode
    ls_req_i = 1; zc_det_i = 0;
    @(negedge clk); chk("R10 ls follows", ls_gate_o, 1);
    zc_det_i = 1;
    @(negedge clk); chk("R10 ls blocked", ls_gate_o, 0);
    zc_det_i = 0;
    @(negedge clk); chk("R10 ls still blocked", ls_gate_o, 0);
    hs_on_i = 1;
    @(negedge clk); chk("R10 ls released", ls_gate_o, 1); chk("R10 hs_gate", hs_gate_o, 1);
    hs_on_i = 0;
    @(negedge clk); chk("R10 hs_gate off", hs_gate_o, 0); chk("R10 ls stays", ls_gate_o, 1);

    // Return to PWM (R5), then check R9 and R10 in PWM mode
    strobe(1'b1, 1'b0);
    chk("R5 eighth high", hyst_o, 0);
    @(negedge clk); pwm_cmp_i = 1; hyst_cmp_i = 1;
    @(negedge clk);
    chk("R9 pwm_path in pwm", pwm_path_o, 1);
    chk("R9 hyst_path in pwm", hyst_path_o, 0);
    zc_det_i = 1;
    @(negedge clk); chk("R10 zc ignored in pwm", ls_gate_o, 1);
    @(negedge clk); chk("R10 zc ignored in pwm 2", ls_gate_o, 1);
    zc_det_i = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule